// File: doc/BRIEF.md
# DMA Bus Ownership and Transfer Cycle Sequencer

This block runs the bus side of a multi-channel DMA engine. When an enabled channel raises its service request, the sequencer asks the processor for the system bus and waits for the acknowledge. Once it owns the bus it runs one transfer cycle after another. Each cycle pairs a memory strobe with the I/O strobe of the opposite direction, and the granted channel's acknowledge marks the whole cycle. When no request remains, the sequencer returns the bus.

The I/O read and write lines have two jobs. While the engine does not own the bus, they are inputs, and the processor uses them to program the engine and read its status; the sequencer passes them on as active-high access pulses. While the engine owns the bus, the sequencer drives them and raises an output enable. Each channel chooses a transfer kind: to memory, from memory, or verify (no strobes). A terminal-count flag goes to the peripheral for the whole of a block's final cycle. Channel address and count registers are kept elsewhere. They supply the per-channel "final transfer" flag that this block consumes.

Top module: `dma_bus_sequencer`

## Requirements
- R1: After reset, hold_req, io_oe, tc and every dack bit are 0, and all four strobes (mem_rd_n, mem_wr_n, io_rd_out_n, io_wr_out_n) are 1.
- R2: A request on a channel whose chan_en bit is 1 raises hold_req one clock after the request is first sampled in idle. A request on a disabled channel leaves hold_req at 0.
- R3: While hold_req is 1 and hold_ack has not yet been sampled high, no dack bit and no strobe is asserted and io_oe stays 0.
- R4: Each transfer lasts one address-setup clock (dack of the granted channel high, strobes inactive), then the strobe clock or clocks, then one release clock (dack still high, strobes inactive). The address-setup clock begins one clock after hold_ack is sampled high.
- R5: Transfer kind per channel, on bits [2c+1:2c] of chan_kind: 2'b01 = to memory (mem_wr_n and io_rd_out_n low together), 2'b10 = from memory (mem_rd_n and io_wr_out_n low together). The other memory and I/O strobes stay high.
- R6: While ready is 0 during a strobe clock, the strobes stay asserted for another clock. The release clock follows the first strobe clock in which ready is 1.
- R7: Kind 2'b00 (and the unused 2'b11) runs a verify cycle: the full sequence with dack and io_oe, but no strobe ever goes low.
- R8: When several enabled channels request at once, the lowest-numbered one is granted first. At most one dack bit is high at any time.
- R9: If a channel's chan_last bit is 1 when it is granted, tc is 1 during every clock of that transfer. That channel's request is then ignored in the arbitration at the end of the transfer.
- R10: At the release clock, if another enabled request is pending, the next address-setup clock follows at once and hold_req stays 1. Otherwise hold_req drops one clock after release.
- R11: io_oe is 1 only while hold_ack is 1 and a transfer is in progress. cpu_rd and cpu_wr are the inverted io_rd_in_n and io_wr_in_n while hold_ack is 0, and are 0 while hold_ack is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | NCH | Per-channel service request |
| chan_en | input | NCH | Per-channel enable |
| chan_kind | input | 2*NCH | Per-channel transfer kind, 2 bits each |
| chan_last | input | NCH | Per-channel flag: next transfer ends the block |
| hold_ack | input | 1 | Bus grant from the processor |
| ready | input | 1 | Low to stretch the strobe clock |
| io_rd_in_n | input | 1 | I/O read line as seen from the processor side |
| io_wr_in_n | input | 1 | I/O write line as seen from the processor side |
| hold_req | output | 1 | Bus request to the processor |
| dack | output | NCH | Per-channel acknowledge for the current transfer |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_out_n | output | 1 | I/O read strobe driven during DMA, active low |
| io_wr_out_n | output | 1 | I/O write strobe driven during DMA, active low |
| io_oe | output | 1 | Drive enable for the I/O strobe lines |
| tc | output | 1 | Terminal count for the final transfer of a block |
| cpu_rd | output | 1 | Processor read access to the engine |
| cpu_wr | output | 1 | Processor write access to the engine |

## Verification
All outputs come from registered state, so the outputs for each clock are fixed by the state after the preceding rising edge. hold_req appears one clock after a request is sampled. Address setup comes one clock after the acknowledge is sampled. Strobes follow one clock later, and each low ready sample adds one clock. Release follows the first ready-high strobe clock, and idle or the next address setup comes one clock after release. The bench drives inputs just after each rising edge. For every scenario it queues the exact output vector expected at each following falling edge, and a monitor pops and compares one vector per falling edge. The processor access outputs are combinational and are checked at the falling edge after the pins are set.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_HOLD = 3'd1,
        SQ_ADDR = 3'd2,
        SQ_STRB = 3'd3,
        SQ_REL  = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        XK_VERIFY   = 2'b00,
        XK_TO_MEM   = 2'b01,
        XK_FROM_MEM = 2'b10,
        XK_SPARE    = 2'b11
    } xfer_kind_t;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } strobe_set_t;

    function automatic strobe_set_t kind_strobes(xfer_kind_t k);
        strobe_set_t s;
        s = '0;
        case (k)
            XK_TO_MEM: begin
                s.mem_wr = 1'b1;
                s.io_rd  = 1'b1;
            end
            XK_FROM_MEM: begin
                s.mem_rd = 1'b1;
                s.io_wr  = 1'b1;
            end
            default: s = '0;
        endcase
        return s;
    endfunction

    function automatic logic in_transfer(seq_state_t st);
        return (st == SQ_ADDR) || (st == SQ_STRB) || (st == SQ_REL);
    endfunction

endpackage

// File: rtl/dma_seq_pick.sv
module dma_seq_pick
    import dma_seq_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    pend_vec,
    input  logic [2*NCH-1:0]  kind_flat,
    input  logic [NCH-1:0]    last_vec,
    input  logic              load,
    output logic              any_pend,
    output logic [IDXW-1:0]   grant_q,
    output xfer_kind_t        kind_q,
    output logic              last_q
);

    logic [IDXW-1:0] win;

    // lowest index wins: the loop walks downward so the last hit is the smallest
    always_comb begin
        win = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_vec[i]) win = IDXW'(i);
        end
    end

    assign any_pend = |pend_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            kind_q  <= XK_VERIFY;
            last_q  <= 1'b0;
        end else if (load) begin
            grant_q <= win;
            kind_q  <= xfer_kind_t'(kind_flat[2*win +: 2]);
            last_q  <= last_vec[win];
        end
    end

    p_load_has_winner_r8: assert property (@(posedge clk) disable iff (rst)
        load |-> any_pend);

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       any_pend,
    input  logic       hold_ack,
    input  logic       ready,
    output seq_state_t state,
    output logic       load
);

    seq_state_t nxt;

    always_comb begin
        nxt  = state;
        load = 1'b0;
        case (state)
            SQ_IDLE: if (any_pend) nxt = SQ_HOLD;
            SQ_HOLD: begin
                if (hold_ack) begin
                    if (any_pend) begin
                        nxt  = SQ_ADDR;
                        load = 1'b1;
                    end else begin
                        nxt = SQ_IDLE;
                    end
                end
            end
            SQ_ADDR: nxt = SQ_STRB;
            SQ_STRB: if (ready) nxt = SQ_REL;
            SQ_REL: begin
                if (any_pend) begin
                    nxt  = SQ_ADDR;
                    load = 1'b1;
                end else begin
                    nxt = SQ_IDLE;
                end
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= nxt;
    end

    p_wait_for_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_HOLD && !hold_ack) |=> (state == SQ_HOLD));

    p_setup_then_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_ADDR) |=> (state == SQ_STRB));

    p_ready_stretch_r6: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_STRB && !ready) |=> (state == SQ_STRB));

    p_release_after_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_REL) |-> ($past(state) == SQ_STRB));

endmodule

// File: rtl/dma_seq_strobe.sv
module dma_seq_strobe
    import dma_seq_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  seq_state_t      state,
    input  logic [IDXW-1:0] grant_q,
    input  xfer_kind_t      kind_q,
    input  logic            last_q,
    input  logic            hold_ack,
    input  logic            io_rd_in_n,
    input  logic            io_wr_in_n,
    output logic [NCH-1:0]  dack,
    output logic            mem_rd_n,
    output logic            mem_wr_n,
    output logic            io_rd_out_n,
    output logic            io_wr_out_n,
    output logic            io_oe,
    output logic            tc,
    output logic            cpu_rd,
    output logic            cpu_wr
);

    logic        active;
    strobe_set_t act_set;

    assign active  = in_transfer(state);
    assign act_set = (state == SQ_STRB) ? kind_strobes(kind_q) : '0;

    for (genvar c = 0; c < NCH; c++) begin : g_ack
        assign dack[c] = active && (grant_q == IDXW'(c));
    end

    assign mem_rd_n    = ~act_set.mem_rd;
    assign mem_wr_n    = ~act_set.mem_wr;
    assign io_rd_out_n = ~act_set.io_rd;
    assign io_wr_out_n = ~act_set.io_wr;
    assign io_oe       = active && hold_ack;
    assign tc          = active && last_q;
    assign cpu_rd      = !hold_ack && !io_rd_in_n;
    assign cpu_wr      = !hold_ack && !io_wr_in_n;

endmodule

// File: rtl/dma_bus_sequencer.sv
module dma_bus_sequencer
    import dma_seq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   chan_req,
    input  logic [NCH-1:0]   chan_en,
    input  logic [2*NCH-1:0] chan_kind,
    input  logic [NCH-1:0]   chan_last,
    input  logic             hold_ack,
    input  logic             ready,
    input  logic             io_rd_in_n,
    input  logic             io_wr_in_n,
    output logic             hold_req,
    output logic [NCH-1:0]   dack,
    output logic             mem_rd_n,
    output logic             mem_wr_n,
    output logic             io_rd_out_n,
    output logic             io_wr_out_n,
    output logic             io_oe,
    output logic             tc,
    output logic             cpu_rd,
    output logic             cpu_wr
);

    localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1;

    seq_state_t      state;
    logic            load;
    logic            any_pend;
    logic [IDXW-1:0] grant_q;
    xfer_kind_t      kind_q;
    logic            last_q;
    logic [NCH-1:0]  drop_vec;
    logic [NCH-1:0]  pend_vec;

    // a channel finishing its block is left out of the arbitration at release
    assign drop_vec = (state == SQ_REL && last_q) ? dack : '0;
    assign pend_vec = chan_req & chan_en & ~drop_vec;
    assign hold_req = (state != SQ_IDLE);

    dma_seq_pick #(.NCH(NCH), .IDXW(IDXW)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .pend_vec  (pend_vec),
        .kind_flat (chan_kind),
        .last_vec  (chan_last),
        .load      (load),
        .any_pend  (any_pend),
        .grant_q   (grant_q),
        .kind_q    (kind_q),
        .last_q    (last_q)
    );

    dma_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .any_pend (any_pend),
        .hold_ack (hold_ack),
        .ready    (ready),
        .state    (state),
        .load     (load)
    );

    dma_seq_strobe #(.NCH(NCH), .IDXW(IDXW)) u_strobe (
        .state       (state),
        .grant_q     (grant_q),
        .kind_q      (kind_q),
        .last_q      (last_q),
        .hold_ack    (hold_ack),
        .io_rd_in_n  (io_rd_in_n),
        .io_wr_in_n  (io_wr_in_n),
        .dack        (dack),
        .mem_rd_n    (mem_rd_n),
        .mem_wr_n    (mem_wr_n),
        .io_rd_out_n (io_rd_out_n),
        .io_wr_out_n (io_wr_out_n),
        .io_oe       (io_oe),
        .tc          (tc),
        .cpu_rd      (cpu_rd),
        .cpu_wr      (cpu_wr)
    );

    p_one_dack_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    p_no_dack_without_bus_r3: assert property (@(posedge clk) disable iff (rst)
        !hold_req |-> (dack == '0));

    p_strobe_under_dack_r4: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_n || !mem_wr_n || !io_rd_out_n || !io_wr_out_n) |-> (dack != '0));

    p_memrd_pairs_iowr_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_n |-> (!io_wr_out_n && io_rd_out_n && mem_wr_n));

    p_memwr_pairs_iord_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |-> (!io_rd_out_n && io_wr_out_n && mem_rd_n));

    p_drive_needs_ack_r11: assert property (@(posedge clk) disable iff (rst)
        io_oe |-> hold_ack);

    p_tc_inside_xfer_r9: assert property (@(posedge clk) disable iff (rst)
        tc |-> (dack != '0));

endmodule

// File: tb/dma_bus_sequencer_test.sv
module dma_bus_sequencer_test;

    localparam int NCH = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NCH-1:0]   chan_req = '0;
    logic [NCH-1:0]   chan_en = '1;
    logic [2*NCH-1:0] chan_kind = '0;
    logic [NCH-1:0]   chan_last = '0;
    logic             hold_ack = 1'b0;
    logic             ready = 1'b1;
    logic             io_rd_in_n = 1'b1;
    logic             io_wr_in_n = 1'b1;
    logic             hold_req;
    logic [NCH-1:0]   dack;
    logic             mem_rd_n, mem_wr_n, io_rd_out_n, io_wr_out_n;
    logic             io_oe, tc, cpu_rd, cpu_wr;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [10:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    dma_bus_sequencer #(.NCH(NCH)) uut (
        .clk(clk), .rst(rst), .chan_req(chan_req), .chan_en(chan_en),
        .chan_kind(chan_kind), .chan_last(chan_last), .hold_ack(hold_ack),
        .ready(ready), .io_rd_in_n(io_rd_in_n), .io_wr_in_n(io_wr_in_n),
        .hold_req(hold_req), .dack(dack), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .io_rd_out_n(io_rd_out_n), .io_wr_out_n(io_wr_out_n), .io_oe(io_oe),
        .tc(tc), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr)
    );

    wire [10:0] obs = {hold_req, dack, mem_rd_n, mem_wr_n, io_rd_out_n, io_wr_out_n, io_oe, tc};

    // st: 0 no transfer, 1 address setup, 2 strobe, 3 release
    function automatic logic [10:0] ev(bit h, int ch, int st, int md, bit t);
        logic [3:0] d = '0;
        logic mr = 1'b1, mw = 1'b1, ir = 1'b1, iw = 1'b1;
        if (st != 0 && ch >= 0) d[ch] = 1'b1;
        if (st == 2) begin
            if (md == 1) begin mw = 1'b0; ir = 1'b0; end
            else if (md == 2) begin mr = 1'b0; iw = 1'b0; end
        end
        return {h, d, mr, mw, ir, iw, (st != 0), (t && st != 0)};
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(logic [10:0] v, string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(posedge clk); #1;
    endtask

    always @(negedge clk) begin
        if (!rst && exp_q.size() != 0) begin
            logic [10:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {5'd0, obs}, {5'd0, e});
        end
    end

    // one block transfer on channel ch; a = extra hold-wait clocks, w = ready-low clocks
    task automatic single_xfer(int ch, int md, bit last, int w, int a, bit keep, string st_tag);
        chan_kind[2*ch +: 2] = md[1:0];
        chan_last[ch] = last;
        chan_req[ch] = 1'b1;
        push(ev(0, -1, 0, 0, 0), "R2 idle before clock");
        for (int i = 0; i <= a; i++) push(ev(1, -1, 0, 0, 0), i == 0 ? "R2 hold_req" : "R3 wait ack");
        push(ev(1, ch, 1, md, last), "R4 setup");
        for (int i = 0; i <= w; i++) push(ev(1, ch, 2, md, last), i == 0 ? st_tag : "R6 stretched");
        push(ev(1, ch, 3, md, last), "R4 release");
        push(ev(0, -1, 0, 0, 0), keep ? "R9 excluded" : "R10 bus returned");
        if (keep) push(ev(0, -1, 0, 0, 0), "R9 stays idle");
        for (int k = 1; k <= 6 + a + w; k++) begin
            @(posedge clk); #1;
            if (k == 1 + a) hold_ack = 1'b1;
            if (k == 2 + a) begin
                if (!keep) chan_req[ch] = 1'b0;
                if (w > 0) ready = 1'b0;
            end
            if (k == 3 + a + w) ready = 1'b1;
            if (k == 5 + a + w) begin
                chan_req[ch] = 1'b0;
                hold_ack = 1'b0;
            end
        end
        drain();
    endtask

    task automatic two_chan();
        chan_kind[2*1 +: 2] = 2'b01;
        chan_kind[2*2 +: 2] = 2'b10;
        chan_last[1] = 1'b0;
        chan_last[2] = 1'b1;
        chan_req[1] = 1'b1;
        chan_req[2] = 1'b1;
        push(ev(0, -1, 0, 0, 0), "R2 idle");
        push(ev(1, -1, 0, 0, 0), "R2 hold_req");
        push(ev(1, 1, 1, 1, 0), "R8 lower index first");
        push(ev(1, 1, 2, 1, 0), "R5 to memory");
        push(ev(1, 1, 3, 1, 0), "R4 release");
        push(ev(1, 2, 1, 2, 1), "R10 back to back");
        push(ev(1, 2, 2, 2, 1), "R5 from memory");
        push(ev(1, 2, 3, 2, 1), "R9 tc release");
        push(ev(0, -1, 0, 0, 0), "R10 bus returned");
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk); #1;
            if (k == 1) hold_ack = 1'b1;
            if (k == 2) chan_req[1] = 1'b0;
            if (k == 5) chan_req[2] = 1'b0;
            if (k == 8) hold_ack = 1'b0;
        end
        drain();
    endtask

    initial begin
        #750000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 reset outputs", {5'd0, obs}, {5'd0, ev(0, -1, 0, 0, 0)});
        @(posedge clk); #1;

        // R2: disabled channel ignored
        chan_en[3] = 1'b0;
        chan_req[3] = 1'b1;
        for (int i = 0; i < 4; i++) push(ev(0, -1, 0, 0, 0), "R2 disabled ignored");
        drain();
        chan_req[3] = 1'b0;
        chan_en[3] = 1'b1;
        @(posedge clk); #1;

        single_xfer(0, 1, 1'b1, 0, 0, 1'b1, "R5 to memory");
        single_xfer(3, 2, 1'b0, 2, 2, 1'b0, "R5 from memory");
        single_xfer(2, 0, 1'b1, 0, 0, 1'b0, "R7 verify");
        single_xfer(1, 3, 1'b0, 1, 0, 1'b0, "R7 spare kind");
        two_chan();

        // R11: processor access pass-through
        io_rd_in_n = 1'b0;
        @(negedge clk);
        check("R11 cpu_rd", {14'd0, cpu_rd, cpu_wr}, 16'b10);
        check("R11 io_oe idle", {15'd0, io_oe}, 16'd0);
        @(posedge clk); #1;
        io_rd_in_n = 1'b1;
        io_wr_in_n = 1'b0;
        @(negedge clk);
        check("R11 cpu_wr", {14'd0, cpu_rd, cpu_wr}, 16'b01);
        @(posedge clk); #1;
        hold_ack = 1'b1;
        io_rd_in_n = 1'b0;
        @(negedge clk);
        check("R11 gated by ack", {14'd0, cpu_rd, cpu_wr}, 16'b00);
        check("R11 no drive idle", {14'd0, io_oe, hold_req}, 16'b00);
        @(posedge clk); #1;
        hold_ack = 1'b0;
        io_rd_in_n = 1'b1;
        io_wr_in_n = 1'b1;
        repeat (2) @(posedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule